// File: doc/BRIEF.md
# DDR Read Capture Latency Mask

This block sits on the read return path of a 32-bit DDR SDRAM interface built from four byte lanes. It runs on a clock at twice the memory clock rate, so one clock of the block is half a memory cycle. A read command pulse loads a programmable latency setting into a down-counter. Until that counter expires, every strobe transition on the return path is ignored. This keeps the data inputs masked while the bus idles near mid-rail. The setting is chosen so that the window opens during the strobe preamble, before the memory sends its first edge.

Once the window is open, each lane captures its own strobe-qualified bytes, up to one burst of eight beats. The window closes when every lane holds eight beats, or after a fixed timeout. In the timeout case a short-burst error is flagged. The captured beats are then packed in pairs into 64-bit words and delivered as four consecutive valid words. If the latency setting is too large, the leading beats are lost. The delivered data then appears shifted by four bytes for each beat that was missed.

A read that arrives while a burst is being handled is held in a single pending slot. It is launched as soon as the last word of the current burst is delivered.

Top module: `rdcap_top`

## Requirements
- R1: With a latency setting L (0 to 15) sampled at the clock edge that accepts a read, strobe transitions are accepted from the clock edge L+1 edges after the accepting edge onward.
- R2: A strobe transition sampled at any clock edge before the window opens stores no data and uses up no beat.
- R3: A beat on lane l is a sampled strobe level that differs from that lane's level at the previous edge. Each lane counts its own beats, up to 8, and beat i of lane l stores dq bits [8l+7:8l]. Lanes that lag one another still assemble identical words.
- R4: Output word k (k = 0..3) carries beat 2k of lane l in bits [8l+7:8l] and beat 2k+1 of lane l in bits [32+8l+7:32+8l]. A beat that was never captured reads as zero.
- R5: The window closes at the edge where every lane holds 8 beats. On the next four clock edges, word_valid is high for four consecutive cycles and words 0 to 3 appear in order.
- R6: If some lane holds fewer than 8 beats after 16 edges in the window, the window closes anyway. short_err is then high for exactly one cycle, the cycle before the first word. All four words are still delivered.
- R7: Each leading beat lost to a late window shifts the output down by one beat (4 bytes). With the memory's first edge sampled 8 edges after the read, setting 8 gives a first word that starts 4 bytes further on, and setting 9 gives one that starts 8 bytes further on.
- R8: A read that arrives while the block is busy is held, together with the setting present at that moment. It is launched at the edge that delivers the final word of the current burst. A further read that arrives while one is already held is dropped.
- R9: Changes on rd_lat after a read is accepted or held have no effect on that read.
- R10: A synchronous reset drops word_valid and short_err in the next cycle and abandons any burst in progress, so that burst delivers no words.
- R11: Setting 0 opens the window at the accepting edge itself, so transitions sampled from the next edge onward are captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the memory clock rate |
| rst | input | 1 | Synchronous active-high reset |
| rd_cmd | input | 1 | One-cycle read command pulse |
| rd_lat | input | 4 | Capture latency setting in half memory cycles |
| dqs | input | 4 | Per-lane data strobe, sampled level |
| dq | input | 32 | Read data, one byte per lane |
| word_out | output | 64 | Assembled beat pair |
| word_valid | output | 1 | word_out holds a new word |
| short_err | output | 1 | One-cycle pulse: burst closed by timeout |

## Verification
A latency counter that is off by one edge shows up at once in the first delivered word. Its lower half either holds bytes that belong one beat later, or it picks up preamble noise. Either way the error appears within about twenty cycles of the read. A lane beat counter that is wrong corrupts only that lane's byte column. It can also hold the window open until the timeout, so the words arrive eight or more cycles late and short_err is set. A pending slot that is mishandled shows up as a missing fifth to eighth word, or as a second burst that was captured with the wrong latency.

// File: rtl/rdcap_pkg.sv
package rdcap_pkg;

  // Sequencing of one read: wait for latency, capture window, word delivery
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OPEN = 2'd2,
    ST_EMIT = 2'd3
  } rdcap_state_e;

endpackage

// File: rtl/rdcap_lat_timer.sv
module rdcap_lat_timer #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LAT_W-1:0] load_val,
  output logic             expire
);

  logic [LAT_W-1:0] cnt;
  logic             run;

  // Counts half memory cycles; a zero setting never starts the timer
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
      run <= (load_val != '0);
    end else if (run) begin
      if (cnt == LAT_W'(1)) run <= 1'b0;
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = run && (cnt == LAT_W'(1));

  // R1
  expire_once_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && !load) |=> !expire);

endmodule

// File: rtl/rdcap_lane.sv
module rdcap_lane #(
  parameter int BEATS = 8,
  parameter int W     = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           win,
  input  logic           strobe,
  input  logic [W-1:0]   data,
  output logic [BEATS*W-1:0] store,
  output logic           full_next
);

  localparam int CNT_W = $clog2(BEATS + 1);

  logic             strobe_q;
  logic [CNT_W-1:0] cnt;
  logic             hit;
  logic             full;
  logic             take;

  // Previous level is tracked even while masked so the first edge in the window is real
  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  assign hit       = strobe ^ strobe_q;
  assign full      = (cnt == CNT_W'(BEATS));
  assign take      = win && hit && !full;
  assign full_next = full || (take && (cnt == CNT_W'(BEATS - 1)));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (take)  cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < BEATS; i++) begin : g_slot
    logic [W-1:0] slot;
    always_ff @(posedge clk) begin
      if (rst || clr)                        slot <= '0;
      else if (take && cnt == CNT_W'(i))     slot <= data;
    end
    assign store[i*W +: W] = slot;
  end

  // R2
  masked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!win && !clr) |=> $stable(cnt));

endmodule

// File: rtl/rdcap_top.sv
module rdcap_top
  import rdcap_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int BURST   = 8,
  parameter int LAT_W   = 4,
  parameter int TIMEOUT = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_cmd,
  input  logic [LAT_W-1:0]          rd_lat,
  input  logic [LANES-1:0]          dqs,
  input  logic [LANES*LANE_W-1:0]   dq,
  output logic [2*LANES*LANE_W-1:0] word_out,
  output logic                      word_valid,
  output logic                      short_err
);

  localparam int BEAT_W = LANES * LANE_W;
  localparam int WORD_W = 2 * BEAT_W;
  localparam int WORDS  = BURST / 2;
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int TO_W   = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  rdcap_state_e      st;
  logic              pend;
  logic [LAT_W-1:0]  pend_lat;
  logic [TO_W-1:0]   tcnt;
  logic [WIDX_W-1:0] widx;

  logic              launch;
  logic [LAT_W-1:0]  launch_lat;
  logic              last_emit;
  logic              enter_open;
  logic              close;
  logic              all_full_next;
  logic              expire;
  logic [LANES-1:0]  lane_full_next;
  logic [BURST*LANE_W-1:0] lane_store [LANES];
  logic [WORD_W-1:0] word_sel;

  assign last_emit = (st == ST_EMIT) && (widx == WIDX_W'(WORDS - 1));

  // A held read takes precedence over a new one at the final delivery edge
  always_comb begin
    launch     = 1'b0;
    launch_lat = rd_lat;
    if (st == ST_IDLE && rd_cmd) begin
      launch = 1'b1;
    end else if (last_emit && (pend || rd_cmd)) begin
      launch     = 1'b1;
      launch_lat = pend ? pend_lat : rd_lat;
    end
  end

  assign enter_open    = (launch && launch_lat == '0) || (st == ST_WAIT && expire);
  assign all_full_next = &lane_full_next;
  assign close         = (st == ST_OPEN) &&
                         (all_full_next || tcnt == TO_W'(TIMEOUT - 1));

  rdcap_lat_timer #(.LAT_W(LAT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (launch),
    .load_val (launch_lat),
    .expire   (expire)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rdcap_lane #(.BEATS(BURST), .W(LANE_W)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .clr       (enter_open),
      .win       (st == ST_OPEN),
      .strobe    (dqs[g]),
      .data      (dq[g*LANE_W +: LANE_W]),
      .store     (lane_store[g]),
      .full_next (lane_full_next[g])
    );
  end

  // Beat pair selection: even beat to the low half, odd beat to the high half
  always_comb begin
    word_sel = '0;
    for (int l = 0; l < LANES; l++) begin
      word_sel[l*LANE_W +: LANE_W] =
        lane_store[l][(2*int'(widx))*LANE_W +: LANE_W];
      word_sel[BEAT_W + l*LANE_W +: LANE_W] =
        lane_store[l][(2*int'(widx) + 1)*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      tcnt       <= '0;
      widx       <= '0;
      word_out   <= '0;
      word_valid <= 1'b0;
      short_err  <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      short_err  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (launch) st <= (launch_lat == '0) ? ST_OPEN : ST_WAIT;
        end
        ST_WAIT: begin
          if (expire) st <= ST_OPEN;
        end
        ST_OPEN: begin
          if (close) begin
            st        <= ST_EMIT;
            widx      <= '0;
            short_err <= !all_full_next;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_EMIT: begin
          word_valid <= 1'b1;
          word_out   <= word_sel;
          widx       <= widx + 1'b1;
          if (last_emit) begin
            if (launch) st <= (launch_lat == '0) ? ST_OPEN : ST_WAIT;
            else        st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (enter_open) tcnt <= '0;
    end
  end

  // Single pending slot
  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      pend_lat <= '0;
    end else if (last_emit) begin
      if (pend && rd_cmd) begin
        pend     <= 1'b1;
        pend_lat <= rd_lat;
      end else begin
        pend <= 1'b0;
      end
    end else if (rd_cmd && st != ST_IDLE && !pend) begin
      pend     <= 1'b1;
      pend_lat <= rd_lat;
    end
  end

  // R8
  idle_no_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !pend);

  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    short_err |=> !short_err);

  // R6
  err_before_words_chk: assert property (@(posedge clk) disable iff (rst)
    short_err |-> !word_valid);

  // R5
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(st == ST_EMIT));

  // R10
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!word_valid && !short_err));

endmodule

// File: tb/sim_rdcap_top.sv
module sim_rdcap_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        rd_cmd;
  logic [3:0]  rd_lat;
  logic [3:0]  dqs;
  logic [31:0] dq;
  logic [63:0] word_out;
  logic        word_valid;
  logic        short_err;

  always #4 clk = ~clk;

  rdcap_top u0 (
    .clk        (clk),
    .rst        (rst),
    .rd_cmd     (rd_cmd),
    .rd_lat     (rd_lat),
    .dqs        (dqs),
    .dq         (dq),
    .word_out   (word_out),
    .word_valid (word_valid),
    .short_err  (short_err)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R10";
  bit    started = 1'b0;

  // ---------------- behavioural reference ----------------
  int          m_st = 0;
  int          m_cnt = 0, m_t = 0, m_k = 0, m_pend = 0, m_plat = 0;
  int          m_n [4];
  logic [7:0]  m_mem [4][8];
  logic [3:0]  m_prev = 4'h0;
  logic        exp_valid = 1'b0, exp_err = 1'b0;
  logic [63:0] exp_word = '0;

  logic [63:0] got_w [$];
  int          got_err = 0;

  task automatic m_clear();
    for (int l = 0; l < 4; l++) begin
      m_n[l] = 0;
      for (int b = 0; b < 8; b++) m_mem[l][b] = 8'h00;
    end
  endtask

  task automatic m_start(input int lat);
    if (lat == 0) begin m_st = 2; m_t = 0; m_clear(); end
    else begin m_st = 1; m_cnt = lat; end
  endtask

  always @(posedge clk) begin
    logic [3:0] hit;
    bit done;
    started = 1'b1;
    if (rst) begin
      m_st = 0; m_pend = 0; m_prev = 4'h0;
      exp_valid = 1'b0; exp_err = 1'b0;
      m_clear();
    end else begin
      hit = dqs ^ m_prev;
      exp_valid = 1'b0;
      exp_err = 1'b0;
      case (m_st)
        0: if (rd_cmd) m_start(int'(rd_lat));
        1: begin
          if (m_cnt == 1) begin m_st = 2; m_t = 0; m_clear(); end
          else m_cnt--;
          if (rd_cmd && m_pend == 0) begin m_pend = 1; m_plat = int'(rd_lat); end
        end
        2: begin
          for (int l = 0; l < 4; l++)
            if (hit[l] && m_n[l] < 8) begin
              m_mem[l][m_n[l]] = dq[8*l +: 8];
              m_n[l]++;
            end
          m_t++;
          done = (m_n[0] == 8) && (m_n[1] == 8) && (m_n[2] == 8) && (m_n[3] == 8);
          if (done || m_t == 16) begin m_st = 3; m_k = 0; exp_err = !done; end
          if (rd_cmd && m_pend == 0) begin m_pend = 1; m_plat = int'(rd_lat); end
        end
        default: begin
          exp_valid = 1'b1;
          for (int l = 0; l < 4; l++) begin
            exp_word[8*l +: 8]      = m_mem[l][2*m_k];
            exp_word[32+8*l +: 8]   = m_mem[l][2*m_k+1];
          end
          if (m_k == 3) begin
            if (m_pend != 0) begin
              m_start(m_plat);
              m_pend = rd_cmd ? 1 : 0;
              m_plat = int'(rd_lat);
            end else if (rd_cmd) m_start(int'(rd_lat));
            else m_st = 0;
          end else begin
            m_k++;
            if (rd_cmd && m_pend == 0) begin m_pend = 1; m_plat = int'(rd_lat); end
          end
        end
      endcase
      m_prev = dqs;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (word_valid !== exp_valid || short_err !== exp_err ||
          (exp_valid && word_out !== exp_word)) begin
        errors++;
        $display("FAIL %s cycle compare: valid=%0b err=%0b word=%h expected valid=%0b err=%0b word=%h",
                 cur_req, word_valid, short_err, word_out, exp_valid, exp_err, exp_word);
      end
      if (word_valid) got_w.push_back(word_out);
      if (short_err)  got_err++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_beats(input logic [7:0] base, input int nb, input bit skew);
    int steps;
    steps = skew ? nb + 1 : nb;
    for (int s = 0; s < steps; s++) begin
      @(negedge clk);
      for (int l = 0; l < 4; l++) begin
        int b;
        b = (skew && l == 3) ? s - 1 : s;
        if (b >= 0 && b < nb) begin
          dqs[l] = ~dqs[l];
          dq[8*l +: 8] = base + 8'(4*b + l);
        end
      end
    end
  endtask

  task automatic run_read(input int lat, input logic [7:0] base, input int nb,
                          input bit skew, input bit noise);
    got_w.delete();
    got_err = 0;
    @(negedge clk); rd_cmd = 1'b1; rd_lat = 4'(lat);
    @(negedge clk); rd_cmd = 1'b0; rd_lat = 4'hF;
    for (int k = 2; k < 8; k++) begin
      @(negedge clk);
      if (noise && (k == 3 || k == 4)) begin dqs = ~dqs; dq = 32'hEEEE_EEEE; end
    end
    send_beats(base, nb, skew);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; rd_cmd = 1'b0; rd_lat = 4'h0; dqs = 4'h0; dq = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", {62'd0, word_valid, short_err}, 64'd0);
    rst = 1'b0;

    // R1 R4 R5 R9: nominal setting, rd_lat disturbed after acceptance
    cur_req = "R5";
    run_read(5, 8'h00, 8, 1'b0, 1'b0);
    chk("R5", 64'(got_w.size()), 64'd4);
    chk("R4", got_w[0], 64'h07060504_03020100);
    chk("R4", got_w[3], 64'h1F1E1D1C_1B1A1918);
    chk("R9", 64'(got_err), 64'd0);

    // R2: preamble noise before the window is ignored
    cur_req = "R2";
    run_read(4, 8'h00, 8, 1'b0, 1'b1);
    chk("R2", got_w[0], 64'h07060504_03020100);
    chk("R2", 64'(got_err), 64'd0);

    // R1: latest setting that still catches the first beat
    cur_req = "R1";
    run_read(7, 8'h40, 8, 1'b0, 1'b0);
    chk("R1", got_w[0], 64'h47464544_43424140);

    // R7 R6: setting 8 loses one beat
    cur_req = "R7";
    run_read(8, 8'h00, 8, 1'b0, 1'b0);
    chk("R7", got_w[0], 64'h0B0A0908_07060504);
    chk("R7", got_w[3], 64'h00000000_1F1E1D1C);
    chk("R6", 64'(got_err), 64'd1);

    // R7: setting 9 loses two beats
    run_read(9, 8'h00, 8, 1'b0, 1'b0);
    chk("R7", got_w[0], 64'h0F0E0D0C_0B0A0908);
    chk("R7", got_w[3], 64'h0);

    // R11: setting 0 opens immediately, so noise is captured
    cur_req = "R11";
    run_read(0, 8'h00, 8, 1'b0, 1'b1);
    chk("R11", got_w[0], 64'hEEEEEEEE_EEEEEEEE);
    chk("R11", got_w[1], 64'h07060504_03020100);

    // R3: lane 3 lags by one beat
    cur_req = "R3";
    run_read(5, 8'h20, 8, 1'b1, 1'b0);
    chk("R3", got_w[0], 64'h27262524_23222120);
    chk("R3", got_w[3], 64'h3F3E3D3C_3B3A3938);

    // R6: short burst of five beats
    cur_req = "R6";
    run_read(5, 8'h00, 5, 1'b0, 1'b0);
    chk("R6", 64'(got_err), 64'd1);
    chk("R6", got_w[2], 64'h00000000_13121110);
    chk("R6", got_w[3], 64'h0);

    // R8: held read with its own setting, third read dropped
    cur_req = "R8";
    got_w.delete(); got_err = 0;
    @(negedge clk); rd_cmd = 1'b1; rd_lat = 4'd5;
    @(negedge clk); rd_cmd = 1'b0; rd_lat = 4'hF;
    @(negedge clk);
    @(negedge clk); rd_cmd = 1'b1; rd_lat = 4'd4;
    @(negedge clk); rd_cmd = 1'b0; rd_lat = 4'hF;
    @(negedge clk); rd_cmd = 1'b1; rd_lat = 4'd2;
    @(negedge clk); rd_cmd = 1'b0; rd_lat = 4'hF;
    @(negedge clk);
    send_beats(8'h00, 8, 1'b0);
    repeat (11) @(negedge clk);
    send_beats(8'h80, 8, 1'b0);
    repeat (40) @(negedge clk);
    chk("R8", 64'(got_w.size()), 64'd8);
    chk("R8", got_w[4], 64'h87868584_83828180);
    chk("R8", 64'(got_err), 64'd0);

    // R10: reset in the middle of a window
    cur_req = "R10";
    got_w.delete(); got_err = 0;
    @(negedge clk); rd_cmd = 1'b1; rd_lat = 4'd5;
    @(negedge clk); rd_cmd = 1'b0;
    repeat (6) @(negedge clk);
    send_beats(8'h00, 2, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10", {62'd0, word_valid, short_err}, 64'd0);
    repeat (30) @(negedge clk);
    chk("R10", 64'(got_w.size()), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule